// File: doc/BRIEF.md
# Windowed Modular Exponentiation Engine

This block raises a base to a power modulo an odd modulus, C = M^e mod N, using the fixed-window method. The exponent is cut into WIN-bit windows. The block first builds a table of the base's powers M^1 … M^(2^WIN - 1). It then walks the windows from the most significant one down. For each window it squares the running value WIN times and multiplies it by the table entry that the window selects. All products go through one bit-serial Montgomery multiplier. Operand A comes from the running-value register or the latched base. Operand B comes from the power-table RAM, the conversion constant, or the running value. Each product is written to the result side: the running value, a table slot, or the output register.

Inputs are sampled in the clock cycle where `start_i` is high and the engine is idle. Later changes to the inputs have no effect on that run. The caller must supply R2 = 2^(2·W) mod N, because the engine works in the Montgomery domain with R = 2^W. `done_o` is a one-cycle pulse, and `result_o` holds C until the next result. This is a control-style interface with no back-pressure. A `start_i` pulse that arrives while a run is in progress is dropped, so the caller waits for `done_o` before issuing the next job.

Top module: `modexp_window`

## Requirements
- R1: For an odd N ≥ 3, a base M < N, any W-bit exponent e and R2 = 2^(2W) mod N, `result_o` equals M^e mod N in the cycle where `done_o` is high.
- R2: When e = 0, `result_o` is 1 and `done_o` rises on the same clock edge that accepts `start_i`.
- R3: Window k covers exponent bits [k·WIN+WIN-1 : k·WIN], with the exponent zero-extended to a whole number of windows. The running value starts from the table entry of the highest nonzero window. Entry 1 holds M itself, and entry 0 is never read or written.
- R4: Below the top nonzero window, each window costs exactly WIN squarings. It adds one table multiplication only if its value is nonzero. A zero window adds no product and no idle cycles.
- R5: Products are strictly sequential on one multiplier, one product every P = W+4 cycles. For e ≠ 0, with T the index of the top nonzero window and Z the number of nonzero windows below it, `done_o` rises (2^WIN + T·WIN + Z)·P + 2 clock edges after the accepting edge.
- R6: For an exponent whose windows are all nonzero and for which W is a multiple of WIN, table and main-loop products total 2^WIN − 2 + (W/WIN − 1)·(WIN+1), which is 125 for W = 60 and WIN = 6. Domain entry and exit add two more, so latency is 127·64 + 2 = 8130 cycles.
- R7: `done_o` is low after reset and stays high for exactly one cycle per accepted job.
- R8: A `start_i` pulse while a run is in progress is ignored: no extra `done_o`, and the result belongs to the inputs sampled at acceptance.
- R9: Every Montgomery product, including the final C, is below N.
- R10: Leading zero windows cost nothing: a short exponent starts its main loop at its own top window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Job request, sampled when idle |
| base_i | input | W | Base M, must be below N |
| exp_i | input | W | Exponent e |
| mod_i | input | W | Odd modulus N |
| r2_i | input | W | Conversion constant 2^(2W) mod N |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | W | Result C, held until the next completion |

## Verification
The assertions take for granted that the modulus is odd and at least 3, that the base is already reduced below it, and that R2 matches the modulus. The bound on multiplier results and the table-slot checks rely on these conditions. The stimulus uses only odd moduli, computes R2 itself with wide arithmetic, and picks bases below the modulus, including 0 and N−1. Exponents are chosen to hit the window corner cases: all windows nonzero, interior zero windows, a lone top window of value 1, leading zero windows and e = 0.

// File: rtl/mx_pkg.sv
package mx_pkg;
  // sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_TOPA,
    ST_TOPB
  } seq_st_e;

  // product kinds issued to the shared multiplier
  typedef enum logic [2:0] {
    OP_CONV,
    OP_FILL,
    OP_SQR,
    OP_MUL,
    OP_OUT
  } op_e;

  // multiplier states
  typedef enum logic [1:0] {
    MM_IDLE,
    MM_LOAD,
    MM_RUN,
    MM_SUB
  } mm_st_e;
endpackage

// File: rtl/mx_mont_mul.sv
module mx_mont_mul
  import mx_pkg::*;
#(
  parameter int W = 60
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] n,
  output logic         done,
  output logic [W-1:0] res
);
  localparam int CW = $clog2(W);
  localparam int TW = W + 2;

  mm_st_e        st;
  logic [W-1:0]  a_sh, b_r, n_r;
  logic [TW-1:0] acc_t, sum, sum_n, step, diff;
  logic [CW-1:0] cnt;

  // one radix-2 Montgomery step: add b if bit set, add n if odd, halve
  always_comb begin
    sum   = acc_t + (a_sh[0] ? {2'b00, b_r} : '0);
    sum_n = sum + {2'b00, n_r};
    step  = sum[0] ? sum_n : sum;
    diff  = acc_t - {2'b00, n_r};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= MM_IDLE;
      a_sh  <= '0;
      b_r   <= '0;
      n_r   <= '0;
      acc_t <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      res   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        MM_IDLE: if (go) st <= MM_LOAD;
        MM_LOAD: begin
          a_sh  <= a;
          b_r   <= b;
          n_r   <= n;
          acc_t <= '0;
          cnt   <= '0;
          st    <= MM_RUN;
        end
        MM_RUN: begin
          acc_t <= step >> 1;
          a_sh  <= a_sh >> 1;
          cnt   <= cnt + CW'(1);
          if (cnt == CW'(W - 1)) st <= MM_SUB;
        end
        MM_SUB: begin
          res  <= (acc_t >= {2'b00, n_r}) ? diff[W-1:0] : acc_t[W-1:0];
          done <= 1'b1;
          st   <= MM_IDLE;
        end
        default: st <= MM_IDLE;
      endcase
    end
  end

  // R9
  res_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res < n_r));

  // R5
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (st == MM_IDLE));
endmodule

// File: rtl/mx_pow_ram.sv
module mx_pow_ram #(
  parameter int W     = 60,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

  // R3
  zero_slot_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    re |-> (raddr != '0));

  // R3
  zero_slot_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (waddr != '0));
endmodule

// File: rtl/mx_seq.sv
module mx_seq
  import mx_pkg::*;
#(
  parameter int W   = 60,
  parameter int WIN = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [W-1:0]   base_i,
  input  logic [W-1:0]   exp_i,
  input  logic [W-1:0]   mod_i,
  input  logic [W-1:0]   r2_i,
  output logic           done_o,
  output logic [W-1:0]   result_o,
  output logic           mul_go,
  output logic [W-1:0]   mul_a,
  output logic [W-1:0]   mul_b,
  output logic [W-1:0]   mul_n,
  input  logic           mul_done,
  input  logic [W-1:0]   mul_res,
  output logic           ram_we,
  output logic [WIN-1:0] ram_waddr,
  output logic [W-1:0]   ram_wdata,
  output logic           ram_re,
  output logic [WIN-1:0] ram_raddr,
  input  logic [W-1:0]   ram_rdata
);
  localparam int NW = (W + WIN - 1) / WIN;
  localparam int PW = NW * WIN;
  localparam int IW = (NW > 1) ? $clog2(NW) : 1;
  localparam int SW = $clog2(WIN + 1);

  seq_st_e        st;
  op_e            op;
  logic [W-1:0]   m_r, e_r, n_r, r2_r, acc;
  logic [WIN-1:0] fill_k;
  logic [IW-1:0]  widx, top_idx;
  logic [SW-1:0]  sq_left;
  logic [PW-1:0]  e_pad;
  logic [WIN-1:0] win_val [NW];
  logic [WIN-1:0] cur_win;
  logic           wb_done;

  assign e_pad = PW'(e_r);

  generate
    for (genvar g = 0; g < NW; g++) begin : g_win
      assign win_val[g] = e_pad[g*WIN +: WIN];
    end
  endgenerate

  // highest nonzero window
  always_comb begin
    top_idx = '0;
    for (int w = 0; w < NW; w++)
      if (win_val[w] != '0) top_idx = IW'(w);
  end

  assign cur_win = win_val[widx];
  assign wb_done = (st == ST_WAIT) && mul_done;

  // multiplier operand steering
  assign mul_go = (st == ST_ISSUE);
  assign mul_n  = n_r;
  assign mul_a  = (op == OP_CONV) ? m_r : acc;
  always_comb begin
    case (op)
      OP_CONV: mul_b = r2_r;
      OP_FILL: mul_b = ram_rdata;
      OP_MUL:  mul_b = ram_rdata;
      OP_SQR:  mul_b = acc;
      default: mul_b = W'(1);
    endcase
  end

  // power table ports
  assign ram_we    = wb_done && ((op == OP_CONV) || (op == OP_FILL));
  assign ram_waddr = (op == OP_CONV) ? WIN'(1) : fill_k;
  assign ram_wdata = mul_res;
  assign ram_re    = ((st == ST_ISSUE) && ((op == OP_FILL) || (op == OP_MUL))) ||
                     (st == ST_TOPA);
  assign ram_raddr = (st == ST_TOPA) ? win_val[top_idx] :
                     (op == OP_FILL) ? WIN'(1) : cur_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      op       <= OP_CONV;
      m_r      <= '0;
      e_r      <= '0;
      n_r      <= '0;
      r2_r     <= '0;
      acc      <= '0;
      fill_k   <= '0;
      widx     <= '0;
      sq_left  <= '0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start_i) begin
            m_r  <= base_i;
            e_r  <= exp_i;
            n_r  <= mod_i;
            r2_r <= r2_i;
            if (exp_i == '0) begin
              result_o <= W'(1);
              done_o   <= 1'b1;
            end else begin
              op <= OP_CONV;
              st <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: begin
          if (mul_done) begin
            acc <= mul_res;
            st  <= ST_ISSUE;
            case (op)
              OP_CONV: begin
                op     <= OP_FILL;
                fill_k <= WIN'(2);
              end
              OP_FILL: begin
                if (&fill_k) st <= ST_TOPA;
                else fill_k <= fill_k + WIN'(1);
              end
              OP_SQR: begin
                if (sq_left > SW'(1)) begin
                  sq_left <= sq_left - SW'(1);
                end else if (cur_win != '0) begin
                  op <= OP_MUL;
                end else if (widx == '0) begin
                  op <= OP_OUT;
                end else begin
                  widx    <= widx - IW'(1);
                  sq_left <= SW'(WIN);
                end
              end
              OP_MUL: begin
                if (widx == '0) begin
                  op <= OP_OUT;
                end else begin
                  widx    <= widx - IW'(1);
                  sq_left <= SW'(WIN);
                  op      <= OP_SQR;
                end
              end
              default: begin
                result_o <= mul_res;
                done_o   <= 1'b1;
                st       <= ST_IDLE;
              end
            endcase
          end
        end
        ST_TOPA: st <= ST_TOPB;
        ST_TOPB: begin
          acc <= ram_rdata;
          st  <= ST_ISSUE;
          if (top_idx == '0) begin
            op <= OP_OUT;
          end else begin
            widx    <= top_idx - IW'(1);
            sq_left <= SW'(WIN);
            op      <= OP_SQR;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // checker-side count of main-loop products
  logic [15:0] main_cnt;
  logic [15:0] main_exp;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) main_cnt <= '0;
    else if (st == ST_IDLE) main_cnt <= '0;
    else if (mul_go && ((op == OP_SQR) || (op == OP_MUL))) main_cnt <= main_cnt + 16'd1;
  end
  always_comb begin
    main_exp = 16'(top_idx) * 16'(WIN);
    for (int w = 0; w < NW; w++)
      if ((IW'(w) < top_idx) && (win_val[w] != '0)) main_exp = main_exp + 16'd1;
  end

  // R6
  main_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_go && (op == OP_OUT)) |-> (main_cnt == main_exp));

  // R4
  mul_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mul_go && (op == OP_MUL)) |-> (cur_win != '0));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> ($stable(e_r) && $stable(n_r)));
endmodule

// File: rtl/modexp_window.sv
module modexp_window #(
  parameter int W   = 60,
  parameter int WIN = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] mod_i,
  input  logic [W-1:0] r2_i,
  output logic         done_o,
  output logic [W-1:0] result_o
);
  localparam int TBL = 1 << WIN;

  logic           mul_go, mul_done;
  logic [W-1:0]   mul_a, mul_b, mul_n, mul_res;
  logic           ram_we, ram_re;
  logic [WIN-1:0] ram_waddr, ram_raddr;
  logic [W-1:0]   ram_wdata, ram_rdata;

  mx_seq #(.W(W), .WIN(WIN)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .base_i    (base_i),
    .exp_i     (exp_i),
    .mod_i     (mod_i),
    .r2_i      (r2_i),
    .done_o    (done_o),
    .result_o  (result_o),
    .mul_go    (mul_go),
    .mul_a     (mul_a),
    .mul_b     (mul_b),
    .mul_n     (mul_n),
    .mul_done  (mul_done),
    .mul_res   (mul_res),
    .ram_we    (ram_we),
    .ram_waddr (ram_waddr),
    .ram_wdata (ram_wdata),
    .ram_re    (ram_re),
    .ram_raddr (ram_raddr),
    .ram_rdata (ram_rdata)
  );

  mx_mont_mul #(.W(W)) u_mul (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (mul_go),
    .a     (mul_a),
    .b     (mul_b),
    .n     (mul_n),
    .done  (mul_done),
    .res   (mul_res)
  );

  mx_pow_ram #(.W(W), .DEPTH(TBL)) u_tbl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (ram_re),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );
endmodule

// File: tb/modexp_window_tb.sv
module modexp_window_tb;
  localparam int W   = 60;
  localparam int WIN = 6;
  localparam int NW  = (W + WIN - 1) / WIN;
  localparam int TBL = 1 << WIN;
  localparam int P   = W + 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] base = '0, expo = '0, modu = 60'd3, r2 = '0;
  logic         done;
  logic [W-1:0] result;

  always #5 clk = ~clk;

  modexp_window #(.W(W), .WIN(WIN)) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start), .base_i (base),
    .exp_i (expo), .mod_i (modu), .r2_i (r2), .done_o (done), .result_o (result)
  );

  typedef struct {
    logic [W-1:0] c;
    logic [W-1:0] n;
    int           lat;
    int           t0;
    string        tag;
  } item_t;

  item_t q[$];
  int    checks = 0, fails = 0, cyc = 0, ndone = 0;
  logic  prev_done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [W-1:0] mulmod(input logic [W-1:0] a, input logic [W-1:0] b,
                                          input logic [W-1:0] n);
    logic [2*W-1:0] p, r;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    r = p % {{W{1'b0}}, n};
    return r[W-1:0];
  endfunction

  function automatic logic [W-1:0] powmod(input logic [W-1:0] m, input logic [W-1:0] e,
                                          input logic [W-1:0] n);
    logic [W-1:0] acc;
    acc = W'(1);
    for (int i = W - 1; i >= 0; i--) begin
      acc = mulmod(acc, acc, n);
      if (e[i]) acc = mulmod(acc, m, n);
    end
    return acc;
  endfunction

  function automatic logic [W-1:0] calc_r2(input logic [W-1:0] n);
    logic [2*W:0] t;
    t = (2*W+1)'(1) << (2*W);
    t = t % {{(W+1){1'b0}}, n};
    return t[W-1:0];
  endfunction

  // latency rule of R5
  function automatic int latency(input logic [W-1:0] e);
    logic [NW*WIN-1:0] ep;
    int top, nz;
    if (e == '0) return 0;
    ep = (NW*WIN)'(e);
    top = 0;
    nz = 0;
    for (int w = 0; w < NW; w++) if (ep[w*WIN +: WIN] != '0) top = w;
    for (int w = 0; w < top; w++) if (ep[w*WIN +: WIN] != '0) nz++;
    return (TBL + top * WIN + nz) * P + 2;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // driver: push the expected item, then pulse start
  task automatic run(input logic [W-1:0] m, input logic [W-1:0] e,
                     input logic [W-1:0] n, input string tag);
    item_t it;
    @(negedge clk);
    base = m; expo = e; modu = n; r2 = calc_r2(n);
    it.c = powmod(m, e, n); it.n = n; it.lat = latency(e); it.t0 = cyc + 1; it.tag = tag;
    q.push_back(it);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: pop and compare on every completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) begin
        ndone++;
        chk(!prev_done, "R7", "done longer than one cycle", W'(prev_done), '0);
        if (q.size() == 0) begin
          chk(1'b0, "R8", "unexpected done", result, '0);
        end else begin
          item_t it;
          it = q.pop_front();
          chk(result == it.c, it.tag, "result", result, it.c);
          chk(result < it.n, "R9", "result below modulus", result, it.n);
          chk((cyc - it.t0) == it.lat, it.tag, "R5 latency", W'(cyc - it.t0), W'(it.lat));
        end
      end
      prev_done = done;
    end
  end

  localparam logic [W-1:0] N1 = 60'hF123456789ABCDF;
  localparam logic [W-1:0] N2 = 60'h9E3779B97F4A7C1;
  localparam logic [W-1:0] N3 = 60'h000000000000ED5;

  initial begin
    logic [W-1:0] all_nz;
    int n0;
    all_nz = '0;
    for (int w = 0; w < NW; w++) all_nz[w*WIN +: WIN] = 6'h21;

    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R7", "reset done", W'(done), '0);
    chk(result == '0, "R1", "reset result", result, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run(60'h0123456789ABCDE, '0, N1, "R2");                 wait_idle();
    run(60'h0123456789ABCDE, 60'd1, N1, "R3");              wait_idle();
    run(60'h0FEDCBA98765432, all_nz, N1, "R6");             wait_idle();
    run(60'h0777777777777777, 60'h0F0000003F00001, N2, "R4"); wait_idle();
    run(60'h0123456789ABCDE, 60'd1 << 54, N1, "R3");        wait_idle();
    run(60'h0555555555AAAAA, 60'h00000000ABCDE, N2, "R10"); wait_idle();
    run(N3 - 60'd1, 60'hFFFFFFFFFFFFFFF, N3, "R1");         wait_idle();
    run('0, 60'h123456789ABCDEF, N2, "R1");                 wait_idle();
    run(60'h0321321321321321, 60'h800000000000000, N2, "R5"); wait_idle();

    // R8: second start during a run is dropped
    n0 = ndone;
    run(60'h0ABCDEF01234567, 60'h0C3000000000042, N1, "R8");
    repeat (400) @(negedge clk);
    base = 60'h1; expo = 60'h5; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    repeat (300) @(negedge clk);
    chk(ndone == n0 + 1, "R8", "done count", W'(ndone - n0), W'(1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog R5 actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule